// File: doc/BRIEF.md
# Two-Wire Command and Status Byte Slave

This block is a minimal slave on a two-wire serial bus, designed for a host that only ever sends or reads one byte. Both bus lines are sampled on the system clock through synchronizers. The block finds the bus frame markers (START and STOP) and clocks in a seven-bit target address plus a direction bit. The upper part of the address is a fixed pattern. The lower five bits come from an input port, so a board can strap or digitize its own slot number.

When the address matches, the slave acknowledges by pulling the data line low. If the host is writing, the next byte is shifted in and its low six bits go into a command register, which the rest of the chip reads. If the host is reading, a status byte is captured from an input port and driven out MSB first, with no acknowledge slot handling after it. The data line is open drain: the block only outputs a pull-low enable, and the pull-up sits on the board.

Top module: `smb_byte_slave`

## Requirements
- R1: A START (data line falling while the clock line is high) restarts address reception from any state. This includes a START in the middle of an address.
- R2: After START, the first seven clock-high samples form the address, MSB first. It matches only when its two top bits are `01` and its low five bits equal `addr_lo_i`. The eighth sample is the direction bit: 0 means write, 1 means read.
- R3: On a match, `sda_pull_o` goes high during the clock-low phase after the eighth rising edge. It stays high through the ninth rising edge and drops after the following falling edge.
- R4: On a mismatch, `sda_pull_o` stays low until the next START, so every later bit the host samples reads as 1.
- R5: In a write, the command byte is shifted in MSB first. Only its low six bits are stored in `cmd_o`. They are stored at the falling clock edge that ends the eighth command bit, not at its rising edge.
- R6: `cmd_o` changes only by a matched write. Reads, STOPs and unmatched addresses leave it unchanged.
- R7: The slave acknowledges the command byte of a matched write by pulling the data line low in the ninth slot.
- R8: In a read, `status_i` is captured when the address acknowledge ends. It is sent MSB first. A change of `status_i` after that point does not affect the byte in flight.
- R9: In the ninth slot after a read byte, the slave leaves the data line released, so the line reads 1. After that slot it stays silent until the next START.
- R10: Reset clears `cmd_o` and the status capture register, and releases the data line at once, including in the middle of an acknowledge.
- R11: `sda_pull_o` changes only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the board |
| sda_i | input | 1 | Bus data line as seen on the board |
| addr_lo_i | input | 5 | Low five bits of this slave's address |
| status_i | input | 8 | Status byte returned on a read |
| sda_pull_o | output | 1 | Pull-low enable for the open-drain data line |
| cmd_o | output | 6 | Latched command bits |

## Verification
The assertions assume that the host changes the data line only while the clock line is low, except at START and STOP. They also assume each clock phase lasts several system clocks, longer than the synchronizer and edge-detect delay, so that a clock edge and a data change never fall in the same sampled cycle. The bench host keeps to this: it moves the data line only at the start of a low phase, and uses quarter phases of eight system clocks and high phases of sixteen. The sweep covers all 128 seven-bit addresses against one strapped value, plus a spread of command bytes.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_ADDR_DEC,
    S_ACK_A,
    S_WR,
    S_WR_LATCH,
    S_ACK_W,
    S_RD,
    S_RD_END,
    S_WAIT
  } smb_state_e;
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '1;
    else     chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/smb_cond_detect.sv
module smb_cond_detect (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_byte_engine.sv
module smb_byte_engine
  import smb_pkg::*;
#(
  parameter int          BYTE_W    = 8,
  parameter int          ADDR_LO_W = 5,
  parameter int          CMD_W     = 6,
  parameter logic [1:0]  ADDR_PFX  = 2'b01
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scl_rise,
  input  logic                 scl_fall,
  input  logic                 start_c,
  input  logic                 stop_c,
  input  logic                 sda_s,
  input  logic [ADDR_LO_W-1:0] addr_lo,
  input  logic [BYTE_W-1:0]    status,
  output logic [CMD_W-1:0]     cmd,
  output logic                 pull
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  smb_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [BYTE_W-1:0] tx_q;
  logic              rw_q;
  logic [CMD_W-1:0]  cmd_q;
  logic              pull_q;
  logic              match;

  assign match = (shreg_q[BYTE_W-1 -: 2] == ADDR_PFX) &&
                 (shreg_q[ADDR_LO_W:1] == addr_lo);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      shreg_q <= '0;
      tx_q    <= '0;
      rw_q    <= 1'b0;
      cmd_q   <= '0;
      pull_q  <= 1'b0;
    end else if (start_c) begin
      state_q <= S_ADDR;
      cnt_q   <= '0;
      pull_q  <= 1'b0;
    end else if (stop_c) begin
      state_q <= S_IDLE;
      pull_q  <= 1'b0;
    end else begin
      unique case (state_q)
        S_ADDR, S_WR: if (scl_rise) begin
          shreg_q <= {shreg_q[BYTE_W-2:0], sda_s};
          cnt_q   <= cnt_q + 1'b1;
          if (cnt_q == LAST)
            state_q <= (state_q == S_ADDR) ? S_ADDR_DEC : S_WR_LATCH;
        end
        S_ADDR_DEC: if (scl_fall) begin
          if (match) begin
            pull_q  <= 1'b1;
            rw_q    <= shreg_q[0];
            state_q <= S_ACK_A;
          end else begin
            state_q <= S_WAIT;
          end
        end
        S_ACK_A: if (scl_fall) begin
          cnt_q <= '0;
          if (rw_q) begin
            tx_q    <= {status[BYTE_W-2:0], 1'b0};
            pull_q  <= ~status[BYTE_W-1];
            state_q <= S_RD;
          end else begin
            pull_q  <= 1'b0;
            state_q <= S_WR;
          end
        end
        S_WR_LATCH: if (scl_fall) begin
          cmd_q   <= shreg_q[CMD_W-1:0];
          pull_q  <= 1'b1;
          state_q <= S_ACK_W;
        end
        S_ACK_W: if (scl_fall) begin
          pull_q  <= 1'b0;
          state_q <= S_WAIT;
        end
        S_RD: begin
          if (scl_rise) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) state_q <= S_RD_END;
          end
          if (scl_fall) begin
            pull_q <= ~tx_q[BYTE_W-1];
            tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
          end
        end
        S_RD_END: if (scl_fall) begin
          pull_q  <= 1'b0;
          state_q <= S_WAIT;
        end
        default: ;
      endcase
    end
  end

  assign cmd  = cmd_q;
  assign pull = pull_q;

  // R1: a START always reopens address reception with the line released
  p_start_restart_r1: assert property (@(posedge clk) disable iff (rst)
    start_c |=> (state_q == S_ADDR) && (cnt_q == '0) && !pull_q);

  // R3: the address acknowledge keeps the line pulled low
  p_addr_ack_held_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_ACK_A) |-> pull_q);

  // R7: the command acknowledge keeps the line pulled low
  p_cmd_ack_held_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_ACK_W) |-> pull_q);

  // R4 and R9: while waiting for the next START the slave is silent
  p_wait_silent_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_WAIT) |-> !pull_q);

  // R6: the command register moves only at the end of a matched write byte
  p_cmd_write_only_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_q != $past(cmd_q)) |-> $past(state_q == S_WR_LATCH && scl_fall));

  // R11: the pull enable moves only on a clock-low edge or a bus marker
  p_pull_on_low_r11: assert property (@(posedge clk) disable iff (rst)
    (pull_q != $past(pull_q)) |-> $past(scl_fall || start_c || stop_c));

  // R10: reset clears the command and releases the line
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (cmd_q == '0) && !pull_q && (tx_q == '0));
endmodule

// File: rtl/smb_byte_slave.sv
module smb_byte_slave #(
  parameter int         SYNC_STAGES = 2,
  parameter int         BYTE_W      = 8,
  parameter int         ADDR_LO_W   = 5,
  parameter int         CMD_W       = 6,
  parameter logic [1:0] ADDR_PFX    = 2'b01
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic [ADDR_LO_W-1:0] addr_lo_i,
  input  logic [BYTE_W-1:0]    status_i,
  output logic                 sda_pull_o,
  output logic [CMD_W-1:0]     cmd_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] line_raw, line_s;
  logic scl_rise, scl_fall, start_c, stop_c;

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    smb_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .din (line_raw[g]),
      .dout(line_s[g])
    );
  end

  smb_cond_detect u_cond (
    .clk     (clk),
    .rst     (rst),
    .scl_s   (line_s[0]),
    .sda_s   (line_s[1]),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_c (start_c),
    .stop_c  (stop_c)
  );

  smb_byte_engine #(
    .BYTE_W   (BYTE_W),
    .ADDR_LO_W(ADDR_LO_W),
    .CMD_W    (CMD_W),
    .ADDR_PFX (ADDR_PFX)
  ) u_eng (
    .clk     (clk),
    .rst     (rst),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_c (start_c),
    .stop_c  (stop_c),
    .sda_s   (line_s[1]),
    .addr_lo (addr_lo_i),
    .status  (status_i),
    .cmd     (cmd_o),
    .pull    (sda_pull_o)
  );

  // R1: START and clock edges are never reported in the same cycle
  p_marker_exclusive_r1: assert property (@(posedge clk) disable iff (rst)
    $countones({start_c, stop_c, scl_rise, scl_fall}) <= 1);
endmodule

// File: tb/sim_smb_byte_slave.sv
module sim_smb_byte_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam int H = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       host_sda = 1'b1;
  logic [4:0] addr_lo = '0;
  logic [7:0] status = '0;
  logic       sda_pull;
  logic [5:0] cmd;
  logic       sda_line;

  int n_chk = 0;
  int n_bad = 0;
  int viol = 0;
  logic prev_pull = 1'b0;
  logic done = 1'b0;
  logic [5:0] exp_cmd = '0;

  assign sda_line = host_sda & ~sda_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_byte_slave u0 (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .addr_lo_i(addr_lo), .status_i(status),
    .sda_pull_o(sda_pull), .cmd_o(cmd)
  );

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      n_chk++;
      if (viol != 0) begin
        n_bad++;
        $display("FAIL R11 pull changes while SCL high actual=%0d expected=0", viol);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // R11 monitor: the pull enable must not move while the bus clock is high
  always @(negedge clk) begin
    if (!rst && scl && (sda_pull != prev_pull)) viol++;
    prev_pull = sda_pull;
  end

  task automatic bus_start();
    host_sda = 1'b1; wt(Q);
    scl = 1'b1;      wt(Q);
    host_sda = 1'b0; wt(Q);
    scl = 1'b0;      wt(Q);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; wt(Q);
    scl = 1'b1;      wt(Q);
    host_sda = 1'b1; wt(Q);
  endtask

  task automatic wr_bit(input logic b);
    host_sda = b; wt(Q);
    scl = 1'b1;   wt(H);
    scl = 1'b0;
  endtask

  task automatic rd_bit(output logic b);
    host_sda = 1'b1; wt(Q);
    scl = 1'b1;      wt(H/2);
    b = sda_line;    wt(H/2);
    scl = 1'b0;
  endtask

  task automatic send_addr(input logic [6:0] a, input logic rw, output logic ack);
    bus_start();
    for (int i = 6; i >= 0; i--) wr_bit(a[i]);
    wr_bit(rw);
    rd_bit(ack);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] c,
                          output logic ack_a, output logic ack_c);
    send_addr(a, 1'b0, ack_a);
    for (int i = 7; i >= 1; i--) wr_bit(c[i]);
    host_sda = c[0]; wt(Q);
    scl = 1'b1; wt(H);
    // R5: nothing is stored at the rising edge of the eighth bit
    chk("R5 cmd before falling edge", cmd, exp_cmd);
    scl = 1'b0; wt(Q - 1);
    if (ack_a == 1'b0) begin
      chk("R5 cmd after falling edge", cmd, c[5:0]);
      exp_cmd = c[5:0];
    end else begin
      chk("R6 cmd after unmatched write", cmd, exp_cmd);
    end
    wt(1);
    scl = 1'b1; wt(H/2);
    ack_c = sda_line; wt(H/2);
    scl = 1'b0;
    bus_stop();
  endtask

  task automatic do_read(input logic [6:0] a, output logic ack,
                         output logic [7:0] d, output logic slot);
    send_addr(a, 1'b1, ack);
    for (int i = 7; i >= 0; i--) begin
      rd_bit(d[i]);
      if (i == 7) status = ~status;
    end
    rd_bit(slot);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    finish_run();
  end

  initial begin
    logic ack_a, ack_c, ack, slot;
    logic [7:0] d;
    logic [7:0] st;
    logic expm;
    wt(5);
    // R10: reset state
    chk("R10 cmd at reset", cmd, 0);
    chk("R10 pull at reset", sda_pull, 0);
    rst = 1'b0;
    wt(5);

    // R2 R4 R8 R9 R6: sweep all 7-bit addresses with reads
    addr_lo = 5'h0B;
    for (int a = 0; a < 128; a++) begin
      st = 8'(a * 37 + 11);
      status = st;
      do_read(7'(a), ack, d, slot);
      expm = (a[6:5] == 2'b01) && (a[4:0] == 5'h0B);
      chk("R2 address ack", ack, expm ? 0 : 1);
      chk(expm ? "R8 status byte" : "R4 silent after mismatch", d, expm ? st : 8'hFF);
      chk("R9 ninth slot released", slot, 1);
      chk("R6 cmd unchanged by read", cmd, exp_cmd);
    end

    // R5 R7: matched writes over a spread of command bytes
    for (int k = 0; k < 16; k++) begin
      do_write({2'b01, 5'h0B}, 8'(k * 17 ^ 8'h3C), ack_a, ack_c);
      chk("R3 write address ack", ack_a, 0);
      chk("R7 command ack", ack_c, 0);
    end

    // R6 R4: wrong prefix and wrong low field leave cmd alone
    do_write({2'b11, 5'h0B}, 8'hFF, ack_a, ack_c);
    chk("R4 prefix 11 no ack", ack_a, 1);
    chk("R4 no command ack", ack_c, 1);
    do_write({2'b00, 5'h0B}, 8'h15, ack_a, ack_c);
    chk("R4 prefix 00 no ack", ack_a, 1);
    do_write({2'b01, 5'h0A}, 8'h2A, ack_a, ack_c);
    chk("R4 low field mismatch", ack_a, 1);
    chk("R6 cmd unchanged", cmd, exp_cmd);

    // R2: another strap value
    addr_lo = 5'h14;
    do_write({2'b01, 5'h14}, 8'hC7, ack_a, ack_c);
    chk("R2 second strap ack", ack_a, 0);
    chk("R5 upper bits dropped", cmd, 6'h07);

    // R1: START in the middle of an address restarts reception
    bus_start();
    wr_bit(1'b0); wr_bit(1'b1); wr_bit(1'b1);
    do_write({2'b01, 5'h14}, 8'h9E, ack_a, ack_c);
    chk("R1 ack after restart", ack_a, 0);
    chk("R1 cmd after restart", cmd, 6'h1E);

    // R10: reset during the address acknowledge
    bus_start();
    for (int i = 6; i >= 0; i--) wr_bit(i == 5 ? 1'b1 : ((i < 5) ? 1'(5'h14 >> i) : 1'b0));
    wr_bit(1'b0);
    host_sda = 1'b1; wt(Q);
    scl = 1'b1; wt(H/2);
    chk("R3 pull during ack", sda_pull, 1);
    rst = 1'b1; wt(3);
    chk("R10 pull cleared", sda_pull, 0);
    chk("R10 cmd cleared", cmd, 0);
    exp_cmd = '0;
    rst = 1'b0; wt(H/2);
    scl = 1'b0;
    bus_stop();
    wt(10);
    status = 8'h81;
    do_read({2'b01, 5'h14}, ack, d, slot);
    chk("R8 read after reset", d, 8'h81);

    finish_run();
  end
endmodule